// File: doc/BRIEF.md
# SPI Register-Access Slave

This block lets an external SPI master read and write a bank of 16-bit registers that sits in the system clock domain. The serial lines (clock, active-low select, data in) pass through two-flop synchronizers. A state machine clocked by the system clock finds the serial clock edges, decodes a 16-bit command word, then moves whole 16-bit data words to or from the bank through a plain address / write-data / write-strobe / read-data port. The system clock must run fast enough that each serial clock phase lasts at least four system clock cycles.

A frame starts when the select line falls. The first 16 bits form the command word, MSB first. Bits [15:11] must hold the enable pattern `11100`, bit 10 chooses read (1) or write (0), and bits [9:0] give the start address. After each complete data word the register pointer moves up by one. The pointer stops at the last valid address and never wraps. At that point further write words are thrown away and further read words repeat the top register.

The machine has these states. `ST_IDLE` moves to `ST_CMD` when select falls. `ST_CMD` moves to `ST_WRITE`, `ST_LOAD` or `ST_DISCARD` when the command word completes. `ST_LOAD` always moves to `ST_READ`. `ST_READ` returns to `ST_LOAD` at each word end. `ST_WRITE` moves to `ST_COMMIT` at each word end. `ST_COMMIT` returns to `ST_WRITE`, or goes to `ST_DISCARD` when the pointer is at the top. `ST_DISCARD` holds until select rises. Select going high sends every state back to `ST_IDLE`.

Top module: `spi_regbank_slave`

## Requirements
- R1: After reset, `miso` is 0 and `reg_we` is 0.
- R2: A command whose bits [15:11] differ from `11100` performs nothing until `cs_n` rises: no `reg_we` pulse, and `miso` stays 0.
- R3: Command bit 10 set to 1 selects a read and 0 selects a write. Bits [9:0] are the start address. A start address of `NUM_REGS` or above causes the frame to be ignored.
- R4: `mosi` is sampled on rising `sclk` edges and `miso` changes after falling `sclk` edges. Command and data words are sent MSB first, and read data is valid for the master's rising edge.
- R5: Each complete write data word gives exactly one single-cycle `reg_we` pulse. During that pulse, `reg_addr` holds the current pointer and `reg_wdata` holds the word.
- R6: After each complete data word the pointer increments, so a burst of reads or writes covers consecutive addresses.
- R7: After a word is written to address `NUM_REGS-1`, all further words of that frame are discarded.
- R8: In a read burst that reaches address `NUM_REGS-1`, the pointer stays there and every further word returns that register.
- R9: A data word cut short by `cs_n` rising is not written. Complete words before it are kept.
- R10: `miso` is 0 whenever `cs_n` is high or the frame is not a valid read.
- R11: Frames work with `sclk` idling either low or high between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master, 0 when idle |
| reg_addr | output | $clog2(NUM_REGS) | Register bank address (pointer) |
| reg_wdata | output | 16 | Data word to write |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_rdata | input | 16 | Register contents at `reg_addr`, combinational |

## Verification
The hardest cases are at the pointer ceiling. A write burst must run past the top address, a read burst must repeat the top register, and the bench must confirm that the extra words leave no trace. The bench starts bursts at the last two addresses with more words than remain. It counts `reg_we` pulses at the bank model, then reads the top addresses back over SPI. Select is also raised partway through a data word, and frames alternate between `sclk` idling low and idling high.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
    localparam int WORD_W     = 16;
    localparam int CMD_ADDR_W = 10;
    localparam int CNT_W      = $clog2(WORD_W);
    localparam int EN_W       = 5;
    localparam logic [EN_W-1:0] CMD_ENABLE = 5'b11100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_LOAD,
        ST_READ,
        ST_WRITE,
        ST_COMMIT,
        ST_DISCARD
    } rb_state_e;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[i]}};
            else        chain_q <= {chain_q[STAGES-2:0], din[i]};
        end
        assign dout[i] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/spi_rb_shifter.sv
module spi_rb_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mosi_s,
    input  logic              shift_in_en,
    input  logic              load_en,
    input  logic [WORD_W-1:0] load_data,
    input  logic              shift_out_en,
    input  logic              clr_out,
    output logic [WORD_W-1:0] rx_next,
    output logic [WORD_W-1:0] rx_word,
    output logic              miso_bit
);
    logic [WORD_W-1:0] rx_q, tx_q;
    logic              out_q;

    assign rx_next  = {rx_q[WORD_W-2:0], mosi_s};
    assign rx_word  = rx_q;
    assign miso_bit = out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q  <= '0;
            tx_q  <= '0;
            out_q <= 1'b0;
        end else begin
            if (shift_in_en) rx_q <= rx_next;
            if (load_en)           tx_q <= load_data;
            else if (shift_out_en) tx_q <= {tx_q[WORD_W-2:0], 1'b0};
            if (clr_out)           out_q <= 1'b0;
            else if (shift_out_en) out_q <= tx_q[WORD_W-1];
        end
    end
endmodule

// File: rtl/spi_rb_fsm.sv
module spi_rb_fsm
    import spi_rb_pkg::*;
#(
    parameter int NUM_REGS = 64,
    parameter int RA_W     = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sclk_s,
    input  logic [WORD_W-1:0] rx_next,
    output logic [RA_W-1:0]   ptr_o,
    output logic              reg_we,
    output logic              shift_in_en,
    output logic              shift_out_en,
    output logic              load_en,
    output logic              clr_out,
    output logic              miso_en
);
    localparam logic [RA_W-1:0]       LAST     = RA_W'(NUM_REGS - 1);
    localparam logic [CMD_ADDR_W-1:0] LAST_CMD = CMD_ADDR_W'(NUM_REGS - 1);
    localparam int                    RW_BIT   = CMD_ADDR_W;

    rb_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [RA_W-1:0]  ptr_q;
    logic             sclk_prev_q;
    logic             rise, fall, word_done, cmd_ok, at_top;

    assign rise      = sclk_s & ~sclk_prev_q;
    assign fall      = ~sclk_s & sclk_prev_q;
    assign word_done = rise && (cnt_q == CNT_W'(WORD_W - 1));
    assign cmd_ok    = (rx_next[WORD_W-1 -: EN_W] == CMD_ENABLE) &&
                       (rx_next[CMD_ADDR_W-1:0] <= LAST_CMD);
    assign at_top    = (ptr_q == LAST);
    assign ptr_o     = ptr_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (!cs_s) state_d = ST_CMD;
            ST_CMD:     if (word_done) begin
                            if (!cmd_ok)              state_d = ST_DISCARD;
                            else if (rx_next[RW_BIT]) state_d = ST_LOAD;
                            else                      state_d = ST_WRITE;
                        end
            ST_LOAD:    state_d = ST_READ;
            ST_READ:    if (word_done) state_d = ST_LOAD;
            ST_WRITE:   if (word_done) state_d = ST_COMMIT;
            ST_COMMIT:  state_d = at_top ? ST_DISCARD : ST_WRITE;
            ST_DISCARD: state_d = ST_DISCARD;
            default:    state_d = ST_IDLE;
        endcase
        if (cs_s) state_d = ST_IDLE;
    end

    // bit counter, pointer, edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            ptr_q       <= '0;
            sclk_prev_q <= 1'b0;
        end else begin
            sclk_prev_q <= sclk_s;
            if (state_q == ST_IDLE) cnt_q <= '0;
            else if (rise)          cnt_q <= cnt_q + CNT_W'(1);
            if (state_q == ST_CMD && word_done)
                ptr_q <= rx_next[RA_W-1:0];
            else if ((state_q == ST_READ && word_done) || state_q == ST_COMMIT) begin
                if (!at_top) ptr_q <= ptr_q + RA_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        reg_we       = (state_q == ST_COMMIT);
        shift_in_en  = rise && (state_q == ST_CMD || state_q == ST_WRITE);
        shift_out_en = fall && (state_q == ST_READ);
        load_en      = (state_q == ST_LOAD);
        clr_out      = (state_q == ST_IDLE || state_q == ST_CMD);
        miso_en      = (state_q == ST_LOAD || state_q == ST_READ);
    end

    // R5
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);
    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (ptr_q == $past(ptr_q)));
    // R6
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && $past(state_q) == ST_READ) |->
        ((ptr_q == $past(ptr_q) + RA_W'(1)) || (ptr_q == LAST)));
    // R7
    top_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && at_top && !cs_s) |=> (state_q == ST_DISCARD));
endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
    import spi_rb_pkg::*;
#(
    parameter int NUM_REGS = 64,
    parameter int RA_W     = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    output logic [RA_W-1:0]   reg_addr,
    output logic [WORD_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [WORD_W-1:0] reg_rdata
);
    logic [2:0]        sync_out;
    logic              cs_s, sclk_s, mosi_s;
    logic [WORD_W-1:0] rx_next, rx_word;
    logic              shift_in_en, shift_out_en, load_en, clr_out, miso_en, miso_bit;

    spi_rb_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b100)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cs_n, sclk, mosi}),
        .dout  (sync_out)
    );
    assign {cs_s, sclk_s, mosi_s} = sync_out;

    spi_rb_shifter #(.WORD_W(WORD_W)) shifter_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mosi_s       (mosi_s),
        .shift_in_en  (shift_in_en),
        .load_en      (load_en),
        .load_data    (reg_rdata),
        .shift_out_en (shift_out_en),
        .clr_out      (clr_out),
        .rx_next      (rx_next),
        .rx_word      (rx_word),
        .miso_bit     (miso_bit)
    );

    spi_rb_fsm #(.NUM_REGS(NUM_REGS), .RA_W(RA_W)) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_s         (cs_s),
        .sclk_s       (sclk_s),
        .rx_next      (rx_next),
        .ptr_o        (reg_addr),
        .reg_we       (reg_we),
        .shift_in_en  (shift_in_en),
        .shift_out_en (shift_out_en),
        .load_en      (load_en),
        .clr_out      (clr_out),
        .miso_en      (miso_en)
    );

    assign reg_wdata = rx_word;
    assign miso      = miso_bit & miso_en;

    // R10
    miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !miso);
endmodule

// File: tb/spi_regbank_slave_tb_top.sv
module spi_regbank_slave_tb_top;
    localparam int NUM_REGS = 64;
    localparam int RA_W     = $clog2(NUM_REGS);
    localparam int H        = 8;

    typedef struct packed {
        logic [9:0]  addr;
        logic [15:0] val;
    } vec_t;
    localparam vec_t VECS [6] = '{
        '{10'd0,  16'h8001}, '{10'd63, 16'h7FFE}, '{10'd1,  16'h1234},
        '{10'd33, 16'hC3A5}, '{10'd7,  16'h0001}, '{10'd42, 16'hFFFF}};

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, sclk, cs_n, mosi, miso, reg_we;
    logic [RA_W-1:0] reg_addr;
    logic [15:0]     reg_wdata, reg_rdata;

    spi_regbank_slave #(.NUM_REGS(NUM_REGS)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata));

    function automatic logic [15:0] init_val(input int i);
        return 16'(i * 16'h0101) ^ 16'hA5A5;
    endfunction

    logic [15:0] bank [NUM_REGS];
    int we_cnt;
    assign reg_rdata = bank[reg_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) bank[i] <= init_val(i);
            we_cnt <= 0;
        end else if (reg_we) begin
            bank[reg_addr] <= reg_wdata;
            we_cnt <= we_cnt + 1;
        end
    end

    logic [15:0] exp_bank [NUM_REGS];
    logic [15:0] tx_buf [8];
    logic [15:0] rx_buf [8];
    int total = 0, bad = 0, w0;
    bit finished = 0;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wait_h(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit idle_hi, input logic b, output logic r);
        if (idle_hi) begin
            sclk = 1'b0; mosi = b; wait_h(H); r = miso; sclk = 1'b1; wait_h(H);
        end else begin
            mosi = b; wait_h(H); r = miso; sclk = 1'b1; wait_h(H); sclk = 1'b0;
        end
    endtask

    task automatic send_word(input bit idle_hi, input logic [15:0] w, output logic [15:0] r);
        for (int k = 15; k >= 0; k--) send_bit(idle_hi, w[k], r[k]);
    endtask

    task automatic spi_frame(input bit idle_hi, input logic [15:0] cmd,
                             input int nwords, input int tail);
        logic [15:0] dummy;
        logic        db;
        sclk = idle_hi; cs_n = 1'b0; wait_h(H);
        send_word(idle_hi, cmd, dummy);
        for (int w = 0; w < nwords; w++) send_word(idle_hi, tx_buf[w], rx_buf[w]);
        for (int t = 0; t < tail; t++) send_bit(idle_hi, 1'b1, db);
        wait_h(H); cs_n = 1'b1; sclk = idle_hi; wait_h(4 * H);
    endtask

    function automatic logic [15:0] mk_cmd(input logic [4:0] en, input bit rd, input int a);
        return {en, rd, 10'(a)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0;
        for (int i = 0; i < NUM_REGS; i++) exp_bank[i] = init_val(i);
        wait_h(5);
        chk("R1 miso", {15'd0, miso}, 16'h0);
        chk("R1 reg_we", {15'd0, reg_we}, 16'h0);
        rst_n = 1'b1; wait_h(5);

        // table walk: single writes, then single reads (R3 R4 R5 R11)
        for (int v = 0; v < 6; v++) begin
            w0 = we_cnt;
            tx_buf[0] = VECS[v].val;
            spi_frame(v[0], mk_cmd(5'b11100, 1'b0, int'(VECS[v].addr)), 1, 0);
            exp_bank[VECS[v].addr] = VECS[v].val;
            chk("R5 one strobe per word", 16'(we_cnt - w0), 16'd1);
            chk("R10 miso idle after write", {15'd0, miso}, 16'h0);
        end
        for (int v = 0; v < 6; v++) begin
            spi_frame(~v[0], mk_cmd(5'b11100, 1'b1, int'(VECS[v].addr)), 1, 0);
            chk("R4 R11 read value", rx_buf[0], VECS[v].val);
        end

        // R6 burst write then wider burst read
        w0 = we_cnt;
        tx_buf[0] = 16'h1111; tx_buf[1] = 16'h2222; tx_buf[2] = 16'h3333;
        spi_frame(1'b0, mk_cmd(5'b11100, 1'b0, 10), 3, 0);
        for (int i = 0; i < 3; i++) exp_bank[10 + i] = tx_buf[i];
        chk("R6 burst strobes", 16'(we_cnt - w0), 16'd3);
        spi_frame(1'b1, mk_cmd(5'b11100, 1'b1, 9), 5, 0);
        for (int i = 0; i < 5; i++) chk("R6 burst read", rx_buf[i], exp_bank[9 + i]);

        // R7 write past top is discarded
        w0 = we_cnt;
        tx_buf[0] = 16'hAAA1; tx_buf[1] = 16'hBBB2; tx_buf[2] = 16'hCCC3; tx_buf[3] = 16'hDDD4;
        spi_frame(1'b0, mk_cmd(5'b11100, 1'b0, 62), 4, 0);
        exp_bank[62] = 16'hAAA1; exp_bank[63] = 16'hBBB2;
        chk("R7 strobes at ceiling", 16'(we_cnt - w0), 16'd2);
        spi_frame(1'b0, mk_cmd(5'b11100, 1'b1, 62), 2, 0);
        chk("R7 reg 62", rx_buf[0], exp_bank[62]);
        chk("R7 reg 63 kept", rx_buf[1], exp_bank[63]);

        // R8 read burst repeats top register
        spi_frame(1'b1, mk_cmd(5'b11100, 1'b1, 63), 3, 0);
        for (int i = 0; i < 3; i++) chk("R8 top repeat", rx_buf[i], exp_bank[63]);

        // R2 bad enable pattern, write and read
        w0 = we_cnt;
        tx_buf[0] = 16'hDEAD;
        spi_frame(1'b0, mk_cmd(5'b11110, 1'b0, 5), 1, 0);
        chk("R2 no strobe", 16'(we_cnt - w0), 16'd0);
        spi_frame(1'b0, mk_cmd(5'b01100, 1'b1, 5), 2, 0);
        chk("R2 miso quiet w0", rx_buf[0], 16'h0);
        chk("R2 miso quiet w1", rx_buf[1], 16'h0);
        spi_frame(1'b0, mk_cmd(5'b11100, 1'b1, 5), 1, 0);
        chk("R2 reg 5 unchanged", rx_buf[0], exp_bank[5]);

        // R3 start address out of range
        w0 = we_cnt;
        tx_buf[0] = 16'h5A5A;
        spi_frame(1'b1, mk_cmd(5'b11100, 1'b0, 100), 1, 0);
        chk("R3 out-of-range write", 16'(we_cnt - w0), 16'd0);
        spi_frame(1'b1, mk_cmd(5'b11100, 1'b1, 64), 1, 0);
        chk("R3 out-of-range read", rx_buf[0], 16'h0);

        // R9 partial word dropped
        w0 = we_cnt;
        tx_buf[0] = 16'h0F0F;
        spi_frame(1'b0, mk_cmd(5'b11100, 1'b0, 20), 1, 7);
        exp_bank[20] = 16'h0F0F;
        chk("R9 only full word", 16'(we_cnt - w0), 16'd1);
        spi_frame(1'b0, mk_cmd(5'b11100, 1'b1, 20), 2, 0);
        chk("R9 reg 20", rx_buf[0], exp_bank[20]);
        chk("R9 reg 21 untouched", rx_buf[1], exp_bank[21]);
        chk("R10 idle miso", {15'd0, miso}, 16'h0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule